// File: doc/BRIEF.md
# Bit Permutation Network

This block is a purely combinational unit that rearranges or smears the bits of one data word. It offers four operations. The first is generalized reverse, where each enabled layer swaps neighbouring bit groups of one size. The second is generalized OR-combine, where each enabled layer ORs every bit with its partner at that distance. The third is the perfect shuffle, which interleaves bit groups. The fourth is its inverse, the unshuffle. Every layer works at a power-of-two distance, and one bit of the control amount switches the whole layer on or off. No layer can make a separate choice for each bit pair.

An execution pipeline places the unit between operand fetch and write-back. It supplies the operand, the control amount, an operation code and a half-width flag. The half-width flag confines the work to the lower half of the word and clears the upper half of the result. The result settles within the same cycle.

Top module: `bitperm_net`

## Requirements
- R1: With `op_i` = 0 (reverse), `result_o[i]` = `data_i[i XOR c]`, where c is the effective control value.
- R2: With `op_i` = 1 (OR-combine), `result_o[i]` is the OR of `data_i[i XOR s]` over every s whose set bits all lie within c. The result therefore contains every set bit of the operand.
- R3: With `op_i` = 2 (shuffle), `result_o[i]` = `data_i[j]`. Here j starts at i, and for k taken in ascending order, bits k and k+1 of j are exchanged whenever control bit k is set.
- R4: With `op_i` = 3 (unshuffle), the mapping is the same as in R3 but k is taken in descending order. For the same control value, unshuffle therefore undoes shuffle.
- R5: The operation codes on `op_i` are 0 for reverse, 1 for OR-combine, 2 for shuffle and 3 for unshuffle.
- R6: In full-width mode (`half_i` = 0) on a 64-bit word, reverse and OR-combine use only `amount_i[5:0]` and the shuffles use only `amount_i[4:0]`. Higher bits have no effect.
- R7: In half-width mode (`half_i` = 1), reverse and OR-combine use `amount_i[4:0]` and the shuffles use `amount_i[3:0]`. Only the lower 32 operand bits take part, and `result_o[63:32]` is zero.
- R8: An effective control value of zero passes the operand through unchanged. In half-width mode this applies to the lower half only.
- R9: Reverse, shuffle and unshuffle only permute bits, so the number of set bits in the result equals the number in the operand, or in its lower half in half-width mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W (64) | Operand word |
| amount_i | input | CTRL_W (8) | Control amount; one bit per layer |
| op_i | input | 2 | Operation select (see R5) |
| half_i | input | 1 | Half-width mode |
| result_o | output | DATA_W (64) | Rearranged result |

## Verification
The hardest cases to reach are the layer-ordering cases, where two adjacent shuffle layers are both enabled. In those cases, applying the layers in the wrong order gives a different but still valid permutation. Seeded single-bit tests miss this because a single set bit lands in many places that look plausible. The bench therefore runs every one of the 256 control values for every operation and both widths. It uses dense operands with many transitions, so that each layer order leaves a unique result. The sweep also covers control values whose only set bits are the ignored high bits. These must give the same result as a zero control amount.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

   typedef enum logic [1:0] {
      BP_REVERSE   = 2'd0,
      BP_ORCOMBINE = 2'd1,
      BP_SHUFFLE   = 2'd2,
      BP_UNSHUFFLE = 2'd3
   } bp_op_e;

   // True when position idx lies in one of the two middle quarters of its
   // 4*2^k block; those are the bits a shuffle layer of order k exchanges.
   function automatic bit shuf_moves(input int idx, input int k);
      int q;
      q = (idx >> k) & 3;
      return (q == 1) || (q == 2);
   endfunction

endpackage

// File: rtl/bitperm_ctl.sv
module bitperm_ctl #(
   parameter int CTRL_W = 8,
   parameter int LG     = 6
) (
   input  logic [CTRL_W-1:0] amount_i,
   input  logic              half_i,
   output logic [LG-1:0]     rev_en_o,
   output logic [LG-2:0]     shf_en_o
);

   // Reverse / OR-combine layers: the top layer crosses the word halves.
   for (genvar k = 0; k < LG; k++) begin : g_rev
      if (k == LG - 1) begin : g_top
         assign rev_en_o[k] = amount_i[k] & ~half_i;
      end else begin : g_low
         assign rev_en_o[k] = amount_i[k];
      end
   end

   // Shuffle layers: the top one spans the whole word.
   for (genvar k = 0; k < LG - 1; k++) begin : g_shf
      if (k == LG - 2) begin : g_top
         assign shf_en_o[k] = amount_i[k] & ~half_i;
      end else begin : g_low
         assign shf_en_o[k] = amount_i[k];
      end
   end

   always_comb begin
      if (half_i && !$isunknown(amount_i)) begin
         p_half_top_off_r7: assert (!rev_en_o[LG-1] && !shf_en_o[LG-2]);
      end
   end

endmodule

// File: rtl/bitperm_swap_stage.sv
module bitperm_swap_stage #(
   parameter int W = 64,
   parameter int K = 0
) (
   input  logic [W-1:0] x_i,
   input  logic         en_i,
   input  logic         merge_i,
   output logic [W-1:0] y_o
);

   localparam int DIST = 1 << K;

   logic [W-1:0] partner;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign partner[i] = x_i[i ^ DIST];
   end

   always_comb begin
      if (!en_i)        y_o = x_i;
      else if (merge_i) y_o = x_i | partner;
      else              y_o = partner;
   end

   always_comb begin
      if (!$isunknown({x_i, en_i, merge_i})) begin
         if (merge_i) begin
            p_merge_superset_r2: assert ((y_o & x_i) == x_i);
         end else begin
            p_swap_count_r1: assert ($countones(y_o) == $countones(x_i));
         end
      end
   end

endmodule

// File: rtl/bitperm_shuf_stage.sv
module bitperm_shuf_stage
   import bitperm_pkg::*;
#(
   parameter int W = 64,
   parameter int K = 0
) (
   input  logic [W-1:0] x_i,
   input  logic         en_i,
   output logic [W-1:0] y_o
);

   localparam int FLIP = 3 << K;

   logic [W-1:0] moved;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (shuf_moves(i, K)) begin : g_mv
         assign moved[i] = x_i[i ^ FLIP];
      end else begin : g_keep
         assign moved[i] = x_i[i];
      end
   end

   assign y_o = en_i ? moved : x_i;

   always_comb begin
      if (!$isunknown({x_i, en_i})) begin
         p_shuf_count_r3: assert ($countones(y_o) == $countones(x_i));
      end
   end

endmodule

// File: rtl/bitperm_net.sv
module bitperm_net
   import bitperm_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CTRL_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [CTRL_W-1:0] amount_i,
   input  logic [1:0]        op_i,
   input  logic              half_i,
   output logic [DATA_W-1:0] result_o
);

   localparam int LG   = $clog2(DATA_W);
   localparam int HALF = DATA_W / 2;
   localparam int NSH  = LG - 1;

   if ((1 << LG) != DATA_W || DATA_W < 8) begin : g_bad_width
      $error("bitperm_net: DATA_W must be a power of two of at least 8");
   end
   if (CTRL_W < LG) begin : g_bad_ctrl
      $error("bitperm_net: CTRL_W must cover one bit per layer");
   end

   logic [LG-1:0]  rev_en;
   logic [NSH-1:0] shf_en;
   logic           merge;
   bp_op_e         op;

   assign op    = bp_op_e'(op_i);
   assign merge = (op == BP_ORCOMBINE);

   bitperm_ctl #(.CTRL_W(CTRL_W), .LG(LG)) u_ctl (
      .amount_i (amount_i),
      .half_i   (half_i),
      .rev_en_o (rev_en),
      .shf_en_o (shf_en)
   );

   // Reverse / OR-combine chain, distance 1 first.
   logic [DATA_W-1:0] rev_st [LG+1];
   assign rev_st[0] = data_i;
   for (genvar k = 0; k < LG; k++) begin : g_rev
      bitperm_swap_stage #(.W(DATA_W), .K(k)) u_stage (
         .x_i     (rev_st[k]),
         .en_i    (rev_en[k]),
         .merge_i (merge),
         .y_o     (rev_st[k+1])
      );
   end

   // Shuffle chain: widest layer first.
   logic [DATA_W-1:0] shf_st [NSH+1];
   assign shf_st[0] = data_i;
   for (genvar p = 0; p < NSH; p++) begin : g_shf
      bitperm_shuf_stage #(.W(DATA_W), .K(NSH-1-p)) u_stage (
         .x_i  (shf_st[p]),
         .en_i (shf_en[NSH-1-p]),
         .y_o  (shf_st[p+1])
      );
   end

   // Unshuffle chain: narrowest layer first.
   logic [DATA_W-1:0] ush_st [NSH+1];
   assign ush_st[0] = data_i;
   for (genvar p = 0; p < NSH; p++) begin : g_ush
      bitperm_shuf_stage #(.W(DATA_W), .K(p)) u_stage (
         .x_i  (ush_st[p]),
         .en_i (shf_en[p]),
         .y_o  (ush_st[p+1])
      );
   end

   logic [DATA_W-1:0] picked;
   always_comb begin
      unique case (op)
         BP_SHUFFLE:   picked = shf_st[NSH];
         BP_UNSHUFFLE: picked = ush_st[NSH];
         default:      picked = rev_st[LG];
      endcase
   end

   assign result_o = half_i ? {{HALF{1'b0}}, picked[HALF-1:0]} : picked;

   logic [DATA_W-1:0] live_in;
   assign live_in = half_i ? {{HALF{1'b0}}, data_i[HALF-1:0]} : data_i;

   always_comb begin
      if (!$isunknown({data_i, amount_i, op_i, half_i})) begin
         if (op != BP_ORCOMBINE) begin
            p_count_kept_r9: assert ($countones(result_o) == $countones(live_in));
         end else begin
            p_gorc_superset_r2: assert ((result_o & live_in) == live_in);
         end
      end
   end

endmodule

// File: tb/bitperm_net_bench.sv
`timescale 1ns/1ps
module bitperm_net_bench;

   logic        clk = 1'b0;
   logic [63:0] data;
   logic [7:0]  amount;
   logic [1:0]  op;
   logic        half;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bitperm_net #(.DATA_W(64), .CTRL_W(8)) u_bitperm_net (
      .data_i   (data),
      .amount_i (amount),
      .op_i     (op),
      .half_i   (half),
      .result_o (result)
   );

   function automatic int swap_bits(int j, int k);
      int a, b;
      a = (j >> k) & 1;
      b = (j >> (k + 1)) & 1;
      if (a != b) j = j ^ (3 << k);
      return j;
   endfunction

   function automatic logic [63:0] model(logic [63:0] d, logic [7:0] a,
                                         logic [1:0] o, logic h);
      logic [63:0] r;
      int lim, cr, cs, sb, j;
      logic acc;
      lim = h ? 32 : 64;
      cr  = h ? (a & 8'h1F) : (a & 8'h3F);
      sb  = h ? 4 : 5;
      cs  = a & ((1 << sb) - 1);
      r   = '0;
      for (int i = 0; i < lim; i++) begin
         case (o)
            2'd0: r[i] = d[i ^ cr];
            2'd1: begin
               acc = 1'b0;
               for (int s = 0; s < 64; s++)
                  if ((s & ~cr) == 0) acc = acc | d[i ^ s];
               r[i] = acc;
            end
            2'd2: begin
               j = i;
               for (int k = 0; k < sb; k++)
                  if (cs[k]) j = swap_bits(j, k);
               r[i] = d[j];
            end
            default: begin
               j = i;
               for (int k = sb - 1; k >= 0; k--)
                  if (cs[k]) j = swap_bits(j, k);
               r[i] = d[j];
            end
         endcase
      end
      return r;
   endfunction

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s op=%0d half=%0d amount=%02h data=%016h got=%016h exp=%016h",
                  tag, op, half, amount, data, got, exp);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] pats [3];
      logic [63:0] exp, live;
      logic [63:0] seed;
      string tag;
      int ce;
      pats[0] = 64'h0123_4567_89AB_CDEF;
      pats[1] = 64'h8000_0000_0000_0001;
      seed    = 64'h9E37_79B9_7F4A_7C15;
      data = '0; amount = '0; op = '0; half = 1'b0;
      for (int o = 0; o < 4; o++) begin
         for (int h = 0; h < 2; h++) begin
            for (int a = 0; a < 256; a++) begin
               seed = seed ^ (seed << 13);
               seed = seed ^ (seed >> 7);
               seed = seed ^ (seed << 17);
               pats[2] = seed;
               for (int p = 0; p < 3; p++) begin
                  @(negedge clk);
                  data = pats[p]; amount = 8'(a); op = 2'(o); half = 1'(h);
                  @(posedge clk);
                  #1;
                  exp = model(data, amount, op, half);
                  ce  = (o < 2) ? (h ? (a & 8'h1F) : (a & 8'h3F))
                                : (h ? (a & 8'h0F) : (a & 8'h1F));
                  if (ce == 0)                  tag = "R8";
                  else if (h == 0 && a >= 64)   tag = "R6";
                  else if (h == 1)              tag = "R7";
                  else if (o == 0)              tag = "R1/R5";
                  else if (o == 1)              tag = "R2/R5";
                  else if (o == 2)              tag = "R3/R5";
                  else                          tag = "R4/R5";
                  check(tag, result, exp);
                  live = h ? {32'h0, data[31:0]} : data;
                  if (o == 1) check("R9 gorc superset", result & live, live);
                  else check("R9 popcount", 64'($countones(result)), 64'($countones(live)));
               end
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule